// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is a bank of 256 byte-wide configuration registers reached through a two-byte I/O window. The host first writes a register number to the lower window address, which latches it as the current index. It then reads or writes the selected register through the upper window address. Reads return the registered contents of the indexed entry on the cycle after the read strobe.

Writes through the data address pass through a per-index filter. Large parts of the index space are read-only. Two registers accept only one particular byte, and any other value written to them is dropped without notice. The remaining indices can be written freely.

The window is closed after reset. It opens only while bit 1 of an external control byte was last written as 1. While it is closed the window claims no bus cycles and changes no state.

Top module: `cfg_window_port`

## Requirements
- R1: After reset the index is 0x00, the window is closed, and the register array holds 0x3C at 0xE0, 0x03 at 0xE2, 0xFC at 0xE3, 0xDE at 0xE6, 0xFE at 0xE7 and 0xBE at 0xE8. Every other entry holds 0x00, and `rdata_o` is 0xFF.
- R2: Only two addresses are decoded: `BASE_ADDR`, which is the index port, and `BASE_ADDR+1`, which is the data port. An access to any other address raises no hit and changes neither the index nor the array.
- R3: `hit_o` is 1 in the cycle after a read or write strobe to a decoded address while the window is open. In all other cycles it is 0.
- R4: A read strobe to either window address while the window is open puts the entry selected by the current index on `rdata_o` one cycle later. Without a read strobe, `rdata_o` holds its value.
- R5: A data-port write is discarded when the index is in 0x00..0xDF, or is 0xE4, 0xE5, 0xE9..0xED, 0xF3, 0xF5, 0xF7, 0xF9..0xFB or 0xFD..0xFF.
- R6: Index 0xE7 stores a write only when the byte is 0xFE, and index 0xE8 stores a write only when the byte is 0xBE. Any other byte leaves these entries unchanged.
- R7: Indices 0xE0..0xE3, 0xE6, 0xEE..0xF2, 0xF4, 0xF6, 0xF8 and 0xFC store any byte written to the data port.
- R8: A strobe on `ctrl_we_i` opens the window when `ctrl_byte_i[1]` is 1 and closes it when that bit is 0. The other bits of the control byte have no effect.
- R9: While the window is closed, a read strobe returns 0xFF on `rdata_o` with no hit, and a write changes neither the index nor the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_we_i | input | 1 | Strobe that loads the external control byte |
| ctrl_byte_i | input | 8 | Control byte; bit 1 opens the window |
| addr_i | input | ADDR_W | I/O address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| hit_o | output | 1 | Registered decoded-access flag |

## Verification
Every result is due exactly one rising edge after the strobe that causes it. An index write, a data write or a control write takes effect at that edge. `hit_o` and `rdata_o` for a strobe driven in cycle n are valid in cycle n+1. The bench drives inputs on the falling edge. Its behavioural model updates on the same rising edge as the design. The outputs are compared with the model on every falling edge, so each comparison sees the result due for the strobe of the previous cycle. Writes are always followed by reads of the same index, so any filtered or accepted byte becomes visible at the ports.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;

  // Result of the per-index write filter
  typedef enum logic [1:0] {
    WR_LOCKED = 2'd0,
    WR_FREE   = 2'd1,
    WR_MATCH  = 2'd2
  } wr_rule_e;

  function automatic wr_rule_e rule_of(input logic [7:0] idx);
    if (idx inside {[8'h00:8'hDF], 8'hE4, 8'hE5, [8'hE9:8'hED], 8'hF3, 8'hF5,
                    8'hF7, [8'hF9:8'hFB], [8'hFD:8'hFF]})
      return WR_LOCKED;
    else if (idx == 8'hE7 || idx == 8'hE8)
      return WR_MATCH;
    else
      return WR_FREE;
  endfunction

  // The only byte a match-locked register accepts
  function automatic logic [7:0] match_value(input logic [7:0] idx);
    return (idx == 8'hE7) ? 8'hFE : 8'hBE;
  endfunction

  function automatic logic [7:0] reset_value(input logic [7:0] idx);
    case (idx)
      8'hE0:   return 8'h3C;
      8'hE2:   return 8'h03;
      8'hE3:   return 8'hFC;
      8'hE6:   return 8'hDE;
      8'hE7:   return 8'hFE;
      8'hE8:   return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfg_window_decode.sv
module cfg_window_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter int EN_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              open_o,
  output logic              idx_wr_o,
  output logic              dat_wr_o,
  output logic              rd_hit_o,
  output logic              acc_hit_o
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

  logic open_q;
  logic at_idx, at_dat;

  always_ff @(posedge clk) begin
    if (rst)            open_q <= 1'b0;
    else if (ctrl_we_i) open_q <= ctrl_byte_i[EN_BIT];
  end

  always_comb begin
    at_idx    = open_q && (addr_i == BASE_ADDR);
    at_dat    = open_q && (addr_i == DATA_ADDR);
    idx_wr_o  = wr_i && at_idx;
    dat_wr_o  = wr_i && at_dat;
    rd_hit_o  = rd_i && (at_idx || at_dat);
    acc_hit_o = (wr_i || rd_i) && (at_idx || at_dat);
  end

  assign open_o = open_q;

  // R8
  open_follows_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_we_i |=> (open_q == $past(ctrl_byte_i[EN_BIT])));

  // R9
  closed_no_access_chk: assert property (@(posedge clk) disable iff (rst)
    !open_q |-> !(idx_wr_o || dat_wr_o || rd_hit_o));

endmodule

// File: rtl/cfg_window_filter.sv
module cfg_window_filter
  import cfg_window_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              dat_wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              mem_we_o
);
  wr_rule_e rule;

  always_comb begin
    rule = rule_of(8'(idx_i));
    unique case (rule)
      WR_FREE:  mem_we_o = dat_wr_i;
      WR_MATCH: mem_we_o = dat_wr_i && (8'(wdata_i) == match_value(8'(idx_i)));
      default:  mem_we_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/cfg_window_regfile.sv
module cfg_window_regfile
  import cfg_window_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        mem[g] <= DATA_W'(reset_value(8'(g)));
      else if (we_i && (idx_i == IDX_W'(g)))
        mem[g] <= wdata_i;
    end

    // R5
    ent_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(we_i && (idx_i == IDX_W'(g))) |=> $stable(mem[g]));
  end

  assign rdata_o = mem[idx_i];

endmodule

// File: rtl/cfg_window_port.sv
module cfg_window_port
  import cfg_window_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_i,
  output logic [7:0]        rdata_o,
  output logic              hit_o
);
  localparam logic [DATA_W-1:0] IDLE_READ = '1;

  logic open_w, idx_wr, dat_wr, rd_hit, acc_hit, mem_we;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] mem_rd;
  logic [DATA_W-1:0] rdata_q;
  logic              hit_q;

  cfg_window_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .EN_BIT(1)) u_dec (
    .clk(clk), .rst(rst), .ctrl_we_i(ctrl_we_i), .ctrl_byte_i(ctrl_byte_i),
    .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i), .open_o(open_w),
    .idx_wr_o(idx_wr), .dat_wr_o(dat_wr), .rd_hit_o(rd_hit), .acc_hit_o(acc_hit)
  );

  cfg_window_filter #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_flt (
    .dat_wr_i(dat_wr), .idx_i(idx_q), .wdata_i(DATA_W'(wdata_i)), .mem_we_o(mem_we)
  );

  cfg_window_regfile #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst(rst), .we_i(mem_we), .idx_i(idx_q),
    .wdata_i(DATA_W'(wdata_i)), .rdata_o(mem_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      rdata_q <= IDLE_READ;
      hit_q   <= 1'b0;
    end else begin
      if (idx_wr) idx_q <= IDX_W'(wdata_i);
      if (rd_i)   rdata_q <= rd_hit ? mem_rd : IDLE_READ;
      hit_q <= acc_hit;
    end
  end

  assign rdata_o = 8'(rdata_q);
  assign hit_o   = hit_q;

  // R2
  idx_only_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    !idx_wr |=> $stable(idx_q));

  // R3
  hit_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_i || rd_i) |=> !hit_o);

  // R6
  match_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && ((idx_q == IDX_W'(8'hE7) && wdata_i != 8'hFE) ||
                (idx_q == IDX_W'(8'hE8) && wdata_i != 8'hBE))) |-> !mem_we);

  // R9
  closed_read_ff_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !open_w) |=> (rdata_o == 8'hFF && !hit_o));

  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_o));

endmodule

// File: tb/cfg_window_port_tb_top.sv
module cfg_window_port_tb_top;
  localparam int BASE = 16'h03F0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl_we_i = 0;
  logic [7:0] ctrl_byte_i = 0;
  logic [15:0] addr_i = 0;
  logic wr_i = 0, rd_i = 0;
  logic [7:0] wdata_i = 0;
  logic [7:0] rdata_o;
  logic hit_o;

  always #2 clk = ~clk;

  cfg_window_port dut_i (
    .clk(clk), .rst(rst), .ctrl_we_i(ctrl_we_i), .ctrl_byte_i(ctrl_byte_i),
    .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i), .rd_i(rd_i),
    .rdata_o(rdata_o), .hit_o(hit_o)
  );

  int checks = 0, errors = 0;
  string cur_req = "R1";

  // behavioural reference model
  int m_mem [256];
  int m_idx, m_rdata;
  bit m_open, m_hit;
  int locked_lo [9] = '{8'h00, 8'hE4, 8'hE5, 8'hE9, 8'hF3, 8'hF5, 8'hF7, 8'hF9, 8'hFD};
  int locked_hi [9] = '{8'hDF, 8'hE4, 8'hE5, 8'hED, 8'hF3, 8'hF5, 8'hF7, 8'hFB, 8'hFF};

  function automatic bit accepts(int idx, int val);
    for (int k = 0; k < 9; k++)
      if (idx >= locked_lo[k] && idx <= locked_hi[k]) return 0;
    if (idx == 'hE7) return val == 'hFE;
    if (idx == 'hE8) return val == 'hBE;
    return 1;
  endfunction

  task automatic model_reset();
    foreach (m_mem[i]) m_mem[i] = 0;
    m_mem['hE0] = 'h3C; m_mem['hE2] = 'h03; m_mem['hE3] = 'hFC;
    m_mem['hE6] = 'hDE; m_mem['hE7] = 'hFE; m_mem['hE8] = 'hBE;
    m_idx = 0; m_rdata = 'hFF; m_open = 0; m_hit = 0;
  endtask

  always @(posedge clk) begin
    if (rst) model_reset();
    else begin
      bit at_win;
      bit prev_open;
      prev_open = m_open;
      at_win = prev_open && (addr_i == BASE || addr_i == BASE + 1);
      m_hit = at_win && (wr_i || rd_i);
      if (rd_i) m_rdata = at_win ? m_mem[m_idx] : 'hFF;
      if (wr_i && at_win) begin
        if (addr_i == BASE) m_idx = wdata_i;
        else if (accepts(m_idx, wdata_i)) m_mem[m_idx] = wdata_i;
      end
      if (ctrl_we_i) m_open = ctrl_byte_i[1];
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (!rst) begin
      check(cur_req, hit_o, m_hit, "hit_o");
      check(cur_req, rdata_o, m_rdata, "rdata_o");
    end
  end

  task automatic cyc(bit w, bit r, int a, int d, bit cw, int cb);
    wr_i = w; rd_i = r; addr_i = a[15:0]; wdata_i = d[7:0];
    ctrl_we_i = cw; ctrl_byte_i = cb[7:0];
    @(negedge clk);
    wr_i = 0; rd_i = 0; ctrl_we_i = 0;
  endtask

  task automatic set_idx(int v);  cyc(1, 0, BASE, v, 0, 0); endtask
  task automatic put(int v);      cyc(1, 0, BASE + 1, v, 0, 0); endtask
  task automatic get(int a);      cyc(0, 1, a, 0, 0, 0); endtask
  task automatic ctrl(int v);     cyc(0, 0, 0, 0, 1, v); endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    check("R1", rdata_o, 'hFF, "rdata after reset");
    check("R1", hit_o, 0, "hit after reset");
    // R9: closed window, reads FF and writes ignored
    cur_req = "R9";
    get(BASE + 1);
    set_idx('hE2);
    put('h55);
    get(BASE);
    // R8: control bits other than bit 1 do nothing
    cur_req = "R8";
    ctrl('hFD);
    get(BASE + 1);
    ctrl('h02);
    // R1: index still 0, read every default
    cur_req = "R1";
    get(BASE + 1);
    for (int i = 0; i < 256; i++) begin set_idx(i); get(BASE + 1); end
    // R5 / R7: write every index then read back
    cur_req = "R7";
    for (int i = 0; i < 256; i++) begin
      set_idx(i); put(i ^ 'hA5); get(BASE + 1); cyc(0, 0, 0, 0, 0, 0);
    end
    cur_req = "R5";
    for (int i = 'hE0; i < 256; i++) begin set_idx(i); put('h3C); get(BASE + 1); end
    // R6: match-locked registers
    cur_req = "R6";
    set_idx('hE7); put('h00); get(BASE + 1); put('hFE); get(BASE + 1);
    set_idx('hE8); put('hFE); get(BASE + 1); put('hBE); get(BASE + 1);
    // R2: other addresses
    cur_req = "R2";
    set_idx('hF0); put('h11);
    cyc(1, 0, BASE + 2, 'h99, 0, 0);
    cyc(1, 0, BASE - 1, 'h33, 0, 0);
    get(BASE + 2);
    get(BASE + 1);
    // R4: read via index address, hold without strobe
    cur_req = "R4";
    get(BASE);
    cyc(0, 0, BASE + 1, 0, 0, 0);
    cyc(0, 0, BASE + 1, 0, 0, 0);
    // R3: hit timing with back-to-back strobes
    cur_req = "R3";
    put('h22); get(BASE + 1); set_idx('hF0); cyc(0, 0, BASE, 0, 0, 0);
    // R8 / R9: close again
    cur_req = "R9";
    ctrl('h00);
    put('h77); set_idx('h00); get(BASE + 1);
    ctrl('h02);
    get(BASE + 1);
    check("R9", rdata_o, 'h22, "index/array kept while closed");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule